// File: doc/BRIEF.md
# Programmable Wait-State Peripheral Bus Master

This block runs single read and write transfers on a plain asynchronous peripheral bus. The bus has a 16-bit address, one chip select, separate read and write strobes and a shared 16-bit data bus. On the internal side, a one-cycle request starts a transfer. A one-cycle acknowledge ends it, and on a read the captured data is valid during that acknowledge.

Every transfer passes through five timed phases. The first is address setup before chip select. The second is chip select to the strobe's leading edge, the third is the strobe pulse and the fourth is strobe release to chip-select release. The last is address hold after chip select goes away. Each phase length comes from its own 8-bit setting, with a value N giving N+1 clocks. The address setting is shared by the first and last phases. Reads and writes have separate setup, pulse and hold settings. Two polarity bits select the active level: one for chip select and one shared by both strobes. All settings are taken when a request is accepted and held for the whole transfer.

Top module: `wsbus_master`

## Requirements
- R1: After acceptance the pins follow a fixed order. The address is valid from the first cycle. Chip select becomes active after the address phase, the strobe is active only inside the chip-select window, and the address returns to zero in the cycle after the address-hold phase. While idle the address is zero.
- R2: A phase whose 8-bit setting is N lasts exactly N+1 clock cycles. For values 0..2 on every phase, the acknowledge arrives 2(A+1)+(S+1)+(W+1)+(H+1) cycles after the accepting edge.
- R3: With every setting at 0 a transfer occupies exactly 5 cycles. With every setting at 255 it occupies exactly 1280 cycles.
- R4: The address-wait setting times both the setup before chip select and the hold after it. A read uses only the read setup, pulse and hold settings, and a write uses only the write ones.
- R5: With a polarity bit at 0, the signals it covers are active-low. Chip-select polarity bit 1 makes chip select active-high. Strobe polarity bit 1 makes both the read and the write strobe active-high.
- R6: On a write, only the write strobe pulses, and the write data is on the data bus from the first address cycle through the last address-hold cycle. On a read, only the read strobe pulses and the block leaves the data bus undriven.
- R7: Read data is sampled at the clock edge that ends the strobe phase and is presented on the read-data output during the acknowledge.
- R8: The acknowledge is high for exactly one cycle, the first cycle after the address-hold phase. A request raised while a transfer is in progress is ignored.
- R9: Changing any setting or polarity bit during a transfer has no effect on that transfer.
- R10: During and right after reset the chip select and both strobes are high, the address is zero and the acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, all pin edges on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request, taken only when idle |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid while ack is high |
| cfg_addr_wait | input | 8 | Address setup and hold length minus one |
| cfg_rd_setup | input | 8 | Read: chip select to strobe, minus one |
| cfg_rd_width | input | 8 | Read strobe width minus one |
| cfg_rd_hold | input | 8 | Read: strobe release to chip-select release, minus one |
| cfg_wr_setup | input | 8 | Write: chip select to strobe, minus one |
| cfg_wr_width | input | 8 | Write strobe width minus one |
| cfg_wr_hold | input | 8 | Write: strobe release to chip-select release, minus one |
| cfg_cs_inv | input | 1 | 1 makes chip select active-high |
| cfg_strobe_inv | input | 1 | 1 makes both strobes active-high |
| bus_addr | output | 16 | Peripheral address |
| bus_cs | output | 1 | Chip select |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_data | inout | 16 | Shared peripheral data bus |

## Verification
Two events can fall in the same cycle. A new request can arrive while a transfer is still running, and the settings can be rewritten while that transfer is being timed. The bench provokes both at once on some transfers of its sweep. It raises a request with a different address and rewrites every setting and polarity bit to the opposite extreme, one cycle after acceptance. It then judges every pin in every cycle against a timeline computed from the original settings. One cycle after the acknowledge it checks that the acknowledge stays low and the address stays zero, which shows that no second transfer was started.

// File: rtl/wsbus_pkg.sv
package wsbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ASU   = 3'd1,
    PH_SETUP = 3'd2,
    PH_WIDTH = 3'd3,
    PH_HOLD  = 3'd4,
    PH_AH    = 3'd5
  } phase_e;
endpackage

// File: rtl/wsbus_phase_timer.sv
module wsbus_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/wsbus_sequencer.sv
module wsbus_sequencer
  import wsbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req,
  input  logic   phase_last,
  output phase_e phase,
  output phase_e nxt_phase,
  output logic   accept,
  output logic   load
);
  always_comb begin
    nxt_phase = phase;
    accept    = 1'b0;
    case (phase)
      PH_IDLE:  if (req) begin nxt_phase = PH_ASU; accept = 1'b1; end
      PH_ASU:   if (phase_last) nxt_phase = PH_SETUP;
      PH_SETUP: if (phase_last) nxt_phase = PH_WIDTH;
      PH_WIDTH: if (phase_last) nxt_phase = PH_HOLD;
      PH_HOLD:  if (phase_last) nxt_phase = PH_AH;
      PH_AH:    if (phase_last) nxt_phase = PH_IDLE;
      default:  nxt_phase = PH_IDLE;
    endcase
  end

  assign load = (nxt_phase != phase);

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= nxt_phase;
  end
endmodule

// File: rtl/wsbus_pin_driver.sv
module wsbus_pin_driver
  import wsbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        nxt_phase,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          cs_inv,
  input  logic          st_inv,
  output logic [AW-1:0] bus_addr,
  output logic          bus_cs,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          oe,
  output logic [DW-1:0] dout
);
  logic busy, cs_on, st_on;

  always_comb begin
    busy  = (nxt_phase != PH_IDLE);
    cs_on = (nxt_phase == PH_SETUP) || (nxt_phase == PH_WIDTH) || (nxt_phase == PH_HOLD);
    st_on = (nxt_phase == PH_WIDTH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_cs   <= 1'b1;
      bus_rd   <= 1'b1;
      bus_wr   <= 1'b1;
      oe       <= 1'b0;
      dout     <= '0;
    end else begin
      bus_addr <= busy ? addr : '0;
      bus_cs   <= ~cs_on ^ cs_inv;
      bus_rd   <= ~(st_on & ~write) ^ st_inv;
      bus_wr   <= ~(st_on & write) ^ st_inv;
      oe       <= busy & write;
      dout     <= (busy & write) ? wdata : '0;
    end
  end
endmodule

// File: rtl/wsbus_master.sv
module wsbus_master
  import wsbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  input  logic [CW-1:0] cfg_addr_wait,
  input  logic [CW-1:0] cfg_rd_setup,
  input  logic [CW-1:0] cfg_rd_width,
  input  logic [CW-1:0] cfg_rd_hold,
  input  logic [CW-1:0] cfg_wr_setup,
  input  logic [CW-1:0] cfg_wr_width,
  input  logic [CW-1:0] cfg_wr_hold,
  input  logic          cfg_cs_inv,
  input  logic          cfg_strobe_inv,
  output logic [AW-1:0] bus_addr,
  output logic          bus_cs,
  output logic          bus_rd,
  output logic          bus_wr,
  inout  wire  [DW-1:0] bus_data
);
  phase_e        phase, nxt_phase;
  logic          accept, load, phase_last;
  logic [CW-1:0] load_val;

  // settings held for the running transfer (R9)
  logic          snap_write, snap_cs_inv, snap_st_inv;
  logic [AW-1:0] snap_addr;
  logic [DW-1:0] snap_wdata;
  logic [CW-1:0] snap_aw, snap_su, snap_wd, snap_hd;

  logic          idle, eff_write, eff_cs_inv, eff_st_inv;
  logic [AW-1:0] eff_addr;
  logic [DW-1:0] eff_wdata;
  logic          drv_oe;
  logic [DW-1:0] drv_data;

  wsbus_sequencer seq_i (
    .clk(clk), .rst(rst), .req(req), .phase_last(phase_last),
    .phase(phase), .nxt_phase(nxt_phase), .accept(accept), .load(load)
  );

  always_comb begin
    case (nxt_phase)
      PH_ASU:   load_val = cfg_addr_wait;
      PH_SETUP: load_val = snap_su;
      PH_WIDTH: load_val = snap_wd;
      PH_HOLD:  load_val = snap_hd;
      PH_AH:    load_val = snap_aw;
      default:  load_val = '0;
    endcase
  end

  wsbus_phase_timer #(.CW(CW)) tmr_i (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .last(phase_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_write  <= 1'b0;
      snap_cs_inv <= 1'b0;
      snap_st_inv <= 1'b0;
      snap_addr   <= '0;
      snap_wdata  <= '0;
      snap_aw     <= '0;
      snap_su     <= '0;
      snap_wd     <= '0;
      snap_hd     <= '0;
    end else if (accept) begin
      snap_write  <= req_write;
      snap_cs_inv <= cfg_cs_inv;
      snap_st_inv <= cfg_strobe_inv;
      snap_addr   <= req_addr;
      snap_wdata  <= req_wdata;
      snap_aw     <= cfg_addr_wait;
      snap_su     <= req_write ? cfg_wr_setup : cfg_rd_setup;
      snap_wd     <= req_write ? cfg_wr_width : cfg_rd_width;
      snap_hd     <= req_write ? cfg_wr_hold  : cfg_rd_hold;
    end
  end

  always_comb begin
    idle       = (phase == PH_IDLE);
    eff_write  = idle ? req_write      : snap_write;
    eff_cs_inv = idle ? cfg_cs_inv     : snap_cs_inv;
    eff_st_inv = idle ? cfg_strobe_inv : snap_st_inv;
    eff_addr   = idle ? req_addr       : snap_addr;
    eff_wdata  = idle ? req_wdata      : snap_wdata;
  end

  wsbus_pin_driver #(.AW(AW), .DW(DW)) pins_i (
    .clk(clk), .rst(rst), .nxt_phase(nxt_phase), .write(eff_write),
    .addr(eff_addr), .wdata(eff_wdata), .cs_inv(eff_cs_inv), .st_inv(eff_st_inv),
    .bus_addr(bus_addr), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .oe(drv_oe), .dout(drv_data)
  );

  assign bus_data = drv_oe ? drv_data : 'z;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= (phase == PH_AH) && phase_last;
      if ((phase == PH_WIDTH) && phase_last && !snap_write)
        rdata <= bus_data;
    end
  end
endmodule

// File: rtl/wsbus_master_chk.sv
module wsbus_master_chk
  import wsbus_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input phase_e phase,
  input logic   bus_cs,
  input logic   bus_rd,
  input logic   bus_wr,
  input logic   cs_inv,
  input logic   st_inv,
  input logic   ack,
  input logic [15:0] bus_addr
);
  logic busy, cs_on, rd_on, wr_on;
  assign busy  = (phase != PH_IDLE);
  assign cs_on = (bus_cs == cs_inv);
  assign rd_on = (bus_rd == st_inv);
  assign wr_on = (bus_wr == st_inv);

  assert_strobe_in_cs_R1: assert property (@(posedge clk) disable iff (rst)
    (busy && (rd_on || wr_on)) |-> cs_on);

  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(phase) != PH_IDLE) |-> $stable(bus_addr));

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(rd_on && wr_on));

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && phase != PH_AH) |=> (phase != PH_IDLE));

  assert_ack_after_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ack |-> (phase == PH_IDLE && $past(phase) == PH_AH));
endmodule

bind wsbus_master wsbus_master_chk chk_i (
  .clk(clk), .rst(rst), .phase(phase), .bus_cs(bus_cs), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .cs_inv(snap_cs_inv), .st_inv(snap_st_inv), .ack(ack),
  .bus_addr(bus_addr)
);

// File: tb/wsbus_master_tb_top.sv
module wsbus_master_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req = 0, req_write = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic [7:0]  c_aw = 0, c_rs = 0, c_rw = 0, c_rh = 0, c_ws = 0, c_ww = 0, c_wh = 0;
  logic        c_csi = 0, c_sti = 0;
  wire         ack, bus_cs, bus_rd, bus_wr;
  wire  [15:0] rdata, bus_addr, bus_d;
  logic        tb_drv = 0;
  logic [15:0] tb_val = 0;
  assign bus_d = tb_drv ? tb_val : 'z;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  wsbus_master dut_i (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .cfg_addr_wait(c_aw),
    .cfg_rd_setup(c_rs), .cfg_rd_width(c_rw), .cfg_rd_hold(c_rh),
    .cfg_wr_setup(c_ws), .cfg_wr_width(c_ww), .cfg_wr_hold(c_wh),
    .cfg_cs_inv(c_csi), .cfg_strobe_inv(c_sti), .bus_addr(bus_addr),
    .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_data(bus_d)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One transfer; the active path gets (aw,su,wd,hd), the other path different values (R4).
  task automatic xfer(input bit wr, input logic [15:0] addr, input logic [15:0] data,
                      input int aw, input int su, input int wd, input int hd,
                      input bit csi, input bit sti, input bit disturb);
    int a, s, w, h, t;
    bit cs_on, st_on;
    logic exp_cs, exp_rd, exp_wr;
    logic [15:0] exp_addr;
    a = aw + 1; s = su + 1; w = wd + 1; h = hd + 1;
    t = 2*a + s + w + h;
    @(negedge clk);
    c_aw = aw[7:0]; c_csi = csi; c_sti = sti;
    if (wr) begin
      c_ws = su[7:0]; c_ww = wd[7:0]; c_wh = hd[7:0];
      c_rs = 8'(su + 3); c_rw = 8'(wd + 4); c_rh = 8'(hd + 5);
    end else begin
      c_rs = su[7:0]; c_rw = wd[7:0]; c_rh = hd[7:0];
      c_ws = 8'(su + 5); c_ww = 8'(wd + 3); c_wh = 8'(hd + 4);
    end
    req = 1; req_write = wr; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req = 0;
    for (int k = 0; k <= t; k++) begin
      if (disturb && k == 1) begin
        c_aw = 8'hFF; c_rs = 8'hFF; c_rw = 8'hFF; c_rh = 8'hFF;
        c_ws = 8'hFF; c_ww = 8'hFF; c_wh = 8'hFF; c_csi = ~csi; c_sti = ~sti;
        req = 1; req_write = ~wr; req_addr = ~addr;
      end
      if (disturb && k == 2) req = 0;
      cs_on    = (k >= a) && (k < a + s + w + h);
      st_on    = (k >= a + s) && (k < a + s + w);
      exp_cs   = (cs_on ? 1'b0 : 1'b1) ^ csi;
      exp_rd   = ((st_on && !wr) ? 1'b0 : 1'b1) ^ sti;
      exp_wr   = ((st_on && wr) ? 1'b0 : 1'b1) ^ sti;
      exp_addr = (k < t) ? addr : 16'h0;
      chk(bus_addr == exp_addr, disturb ? "R9 R1 address" : "R1 address", bus_addr, exp_addr);
      chk(bus_cs == exp_cs, disturb ? "R9 R5 chip select" : "R1 R4 R5 chip select", bus_cs, exp_cs);
      chk(bus_rd == exp_rd, disturb ? "R9 R6 read strobe" : "R4 R5 R6 read strobe", bus_rd, exp_rd);
      chk(bus_wr == exp_wr, disturb ? "R9 R6 write strobe" : "R4 R5 R6 write strobe", bus_wr, exp_wr);
      chk(ack == (k == t), "R2 R3 R8 ack timing", ack, (k == t));
      if (wr && k < t) chk(bus_d == data, "R6 write data on bus", bus_d, data);
      if (k == t && !wr) chk(rdata == data, "R7 read data", rdata, data);
      tb_drv = !wr && st_on;
      tb_val = data;
      @(negedge clk);
    end
    tb_drv = 0;
    chk(ack == 1'b0, "R8 ack single pulse", ack, 0);
    chk(bus_addr == 16'h0, "R8 busy request ignored", bus_addr, 0);
    c_csi = 0; c_sti = 0;
  endtask

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    chk(bus_cs == 1'b1, "R10 cs in reset", bus_cs, 1);
    chk(bus_rd == 1'b1 && bus_wr == 1'b1, "R10 strobes in reset", {bus_rd, bus_wr}, 2'b11);
    chk(ack == 1'b0, "R10 ack in reset", ack, 0);
    chk(bus_addr == 16'h0, "R10 addr in reset", bus_addr, 0);
    rst = 0;
    @(negedge clk);
    chk(bus_cs == 1'b1 && bus_rd == 1'b1 && bus_wr == 1'b1, "R10 idle after reset",
        {bus_cs, bus_rd, bus_wr}, 3'b111);

    // R3 minimum length, both directions
    xfer(0, 16'h1234, 16'hBEEF, 0, 0, 0, 0, 0, 0, 0);
    xfer(1, 16'h4321, 16'hCAFE, 0, 0, 0, 0, 0, 0, 0);

    // R2 sweep of every phase over 0..2, both directions, polarity combos, disturbances
    idx = 0;
    for (int d = 0; d < 2; d++)
      for (int aw = 0; aw < 3; aw++)
        for (int su = 0; su < 3; su++)
          for (int wd = 0; wd < 3; wd++)
            for (int hd = 0; hd < 3; hd++) begin
              xfer(d[0], 16'(16'h0101 * (idx + 1)), 16'(16'hA000 ^ (idx * 16'h0137)),
                   aw, su, wd, hd, idx[0], idx[1], (idx % 7) == 3);
              idx++;
            end

    // R3 maximum length
    xfer(1, 16'hFFFF, 16'h5A5A, 255, 255, 255, 255, 1, 0, 0);
    xfer(0, 16'h8001, 16'hA5A5, 255, 255, 255, 255, 0, 1, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule